// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block holds the floating-point registers of a core that implements both single and double precision in 64-bit registers. Each single-precision value written into the file has its upper half forced to all ones, so a narrow value always sits inside a 64-bit quiet NaN. A single-precision read checks that this boxing is intact. If it is, the read returns the boxed value. If it is not, the read returns a boxed canonical NaN in its place.

The block also keeps the two-bit floating-point context state. This state says whether the unit is switched off, or holds initial, clean or modified register contents. From it the block derives a summary bit that tells a context switch the registers need saving. Any access while the unit is off, or at a precision whose extension is disabled, raises an illegal-instruction flag, and such a write is dropped. A committed write moves the state to modified. Privileged logic outside the block can overwrite the state directly.

Top module: `fp_boxed_regfile`

## Requirements
- R1: A write with `wr_single`=1 stores `{32'hFFFFFFFF, wr_data[31:0]}`. The upper input half is discarded, and the value of `wr_from_load` makes no difference to what is stored.
- R2: A write with `wr_single`=0 stores all 64 bits of `wr_data` unchanged.
- R3: A read with its single select set, of a register whose bits 63:32 are all ones, returns the register contents unchanged.
- R4: A read with its single select set, of a register whose bits 63:32 are not all ones, returns 64'hFFFFFFFF7FC00000. A read with the select clear always returns the raw 64 bits.
- R5: `fs_state` uses the encoding 0 = off, 1 = initial, 2 = clean, 3 = modified. A cycle with `fs_set_en`=1 loads `fs_set_val` at the clock edge. `fs_summary` is 1 exactly when `fs_state` is 3.
- R6: A committed register write while `fs_state` is 1 or 2 moves it to 3, which sets `fs_summary`. A write while the state is already 3 leaves it at 3.
- R7: While `fs_state` is 0, a write (`wr_en`) or a store or read-only access (`chk_en`) drives `illegal` high in the same cycle, and the write changes no register.
- R8: An access at single precision with `f_enable`=0, or at double precision with `d_enable`=0, drives `illegal` high, and such a write changes no register.
- R9: Reads are combinational. A read of the register being written in the same cycle returns the old contents, and the new value appears after the clock edge.
- R10: After reset, `fs_state` is 1, `fs_summary` is 0 and every register holds 0.
- R11: When `fs_set_en` and a committed write fall in the same cycle, the value loaded through `fs_set_val` wins over the move to state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_single | input | 1 | Read port A: 1 = single precision |
| rd_a_data | output | 64 | Read port A data |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_single | input | 1 | Read port B: 1 = single precision |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write request |
| wr_idx | input | 5 | Write register index |
| wr_single | input | 1 | Write precision: 1 = single |
| wr_from_load | input | 1 | Source tag: 1 = memory load, 0 = arithmetic result |
| wr_data | input | 64 | Write data |
| chk_en | input | 1 | Non-writing access (store or compare) this cycle |
| chk_single | input | 1 | Precision of that access: 1 = single |
| f_enable | input | 1 | Single-precision extension enabled |
| d_enable | input | 1 | Double-precision extension enabled |
| fs_set_en | input | 1 | Load a new context state |
| fs_set_val | input | 2 | Context state to load |
| fs_state | output | 2 | Current context state |
| fs_summary | output | 1 | Summary bit: state is modified |
| illegal | output | 1 | Illegal-instruction flag for this cycle's access |

## Verification
The boxing path is tried with single writes whose upper input half is garbage, under both source tags. This shows that boxing ignores both the input upper half and the tag. Double writes are tried with an all-ones upper half, with an upper half that misses by one bit (bit 32 clear, and separately bit 63 clear), and with zero. Single reads of these tell exact boxing detection apart from a partial or sign-only test, and double reads of the same registers show that raw data passes through. The context state is driven through each of its four values, so that dirtying, the blocked writes while off, per-precision blocking and the priority of the direct state load can each be seen apart.

// File: rtl/fp_boxed_regfile.sv
module fp_boxed_regfile #(
  parameter int NREGS = 32,
  parameter int IDXW  = $clog2(NREGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_a_idx,
  input  logic            rd_a_single,
  output logic [63:0]     rd_a_data,
  input  logic [IDXW-1:0] rd_b_idx,
  input  logic            rd_b_single,
  output logic [63:0]     rd_b_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic            wr_single,
  input  logic            wr_from_load,
  input  logic [63:0]     wr_data,
  input  logic            chk_en,
  input  logic            chk_single,
  input  logic            f_enable,
  input  logic            d_enable,
  input  logic            fs_set_en,
  input  logic [1:0]      fs_set_val,
  output logic [1:0]      fs_state,
  output logic            fs_summary,
  output logic            illegal
);
  localparam logic [1:0]  FS_OFF   = 2'd0;
  localparam logic [1:0]  FS_INIT  = 2'd1;
  localparam logic [1:0]  FS_DIRTY = 2'd3;
  localparam logic [31:0] ONES32   = 32'hFFFF_FFFF;
  localparam logic [63:0] QNAN_BOX = {ONES32, 32'h7FC0_0000};

  logic [63:0] regs [NREGS];
  logic [1:0]  fs_q;
  logic        wr_bad, chk_bad, wr_commit;
  logic [63:0] wr_val;

  assign wr_bad    = (fs_q == FS_OFF) || (wr_single ? !f_enable : !d_enable);
  assign chk_bad   = (fs_q == FS_OFF) || (chk_single ? !f_enable : !d_enable);
  assign illegal   = (wr_en && wr_bad) || (chk_en && chk_bad);
  assign wr_commit = wr_en && !wr_bad;
  assign wr_val    = wr_single ? {ONES32, wr_data[31:0]} : wr_data;

  function automatic logic [63:0] unbox(input logic [63:0] v, input logic sp);
    if (sp && v[63:32] != ONES32) return QNAN_BOX;
    return v;
  endfunction

  assign rd_a_data  = unbox(regs[rd_a_idx], rd_a_single);
  assign rd_b_data  = unbox(regs[rd_b_idx], rd_b_single);
  assign fs_state   = fs_q;
  assign fs_summary = (fs_q == FS_DIRTY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (wr_commit) begin
      regs[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fs_q <= FS_INIT;
    else if (fs_set_en) fs_q <= fs_set_val;
    else if (wr_commit) fs_q <= FS_DIRTY;
  end

  // R6
  a_dirty_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fs_q != FS_OFF && !fs_set_en && (wr_single ? f_enable : d_enable)) |=> fs_state == FS_DIRTY);
  // R6
  a_dirty_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_state == FS_DIRTY && !fs_set_en) |=> fs_state == FS_DIRTY);
  // R5
  a_off_only_by_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_state != FS_OFF && !fs_set_en) |=> fs_state != FS_OFF);
  // R7
  a_off_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en || chk_en) && fs_state == FS_OFF) |-> illegal);
  // R7
  a_off_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_state == FS_OFF && !fs_set_en) |=> $stable(rd_a_data) || $past(rd_a_idx) != rd_a_idx || $past(rd_a_single) != rd_a_single);
  // R3 R4
  a_single_read_boxed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_single |-> rd_a_data[63:32] == ONES32);
  // R1
  a_tag_box_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_single && f_enable && fs_q != FS_OFF && wr_idx == rd_b_idx && rd_b_single && (wr_from_load || !wr_from_load))
    |=> (rd_b_idx != $past(rd_b_idx)) || !rd_b_single || rd_b_data[31:0] == $past(wr_data[31:0]));
endmodule

// File: tb/fp_boxed_regfile_bench.sv
module fp_boxed_regfile_bench;
  logic clk = 0, rst_n = 0;
  logic [4:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic rd_a_single = 0, rd_b_single = 0, wr_en = 0, wr_single = 0, wr_from_load = 0;
  logic [63:0] wr_data = 0;
  logic chk_en = 0, chk_single = 0, f_enable = 1, d_enable = 1, fs_set_en = 0;
  logic [1:0] fs_set_val = 0;
  logic [63:0] rd_a_data, rd_b_data;
  logic [1:0] fs_state;
  logic fs_summary, illegal;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  fp_boxed_regfile u_fp_boxed_regfile (.*);

  localparam logic [63:0] NANB = 64'hFFFFFFFF7FC00000;
  // idx, single, load tag, write data, expected double read, expected single read
  typedef struct packed { logic [4:0] idx; logic sp; logic ld; logic [63:0] d; logic [63:0] xd; logic [63:0] xs; } vec_t;
  localparam vec_t VECS [8] = '{
    '{5'd1,  1'b1, 1'b1, 64'h1234_5678_3F80_0000, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_3F80_0000},
    '{5'd2,  1'b1, 1'b0, 64'h1234_5678_3F80_0000, 64'hFFFF_FFFF_3F80_0000, 64'hFFFF_FFFF_3F80_0000},
    '{5'd3,  1'b0, 1'b1, 64'h4009_21FB_5444_2D18, 64'h4009_21FB_5444_2D18, NANB},
    '{5'd4,  1'b0, 1'b0, 64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_1234_5678, 64'hFFFF_FFFF_1234_5678},
    '{5'd5,  1'b0, 1'b1, 64'hFFFF_FFFE_1234_5678, 64'hFFFF_FFFE_1234_5678, NANB},
    '{5'd6,  1'b0, 1'b0, 64'h7FFF_FFFF_0000_0001, 64'h7FFF_FFFF_0000_0001, NANB},
    '{5'd31, 1'b1, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
    '{5'd0,  1'b0, 1'b1, 64'h0,                   64'h0,                   NANB}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] i, input logic sp, input logic ld, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_single = sp; wr_from_load = ld; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] i, input logic sp);
    rd_a_idx = i; rd_a_single = sp; rd_b_idx = i; rd_b_single = !sp;
    #0.5;
  endtask

  task automatic setfs(input logic [1:0] v);
    @(negedge clk);
    fs_set_en = 1; fs_set_val = v;
    @(negedge clk);
    fs_set_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 fs", {62'd0, fs_state}, 64'd1);
    chk("R10 summary", {63'd0, fs_summary}, 64'd0);
    rd(5'd9, 1'b0);
    chk("R10 reg", rd_a_data, 64'd0);
    chk("R4 zero reg single read", rd_b_data, NANB);

    // R6 first write from initial dirties
    wr(5'd10, 1'b0, 1'b0, 64'h1);
    chk("R6 fs dirty", {62'd0, fs_state}, 64'd3);
    chk("R5 summary", {63'd0, fs_summary}, 64'd1);

    foreach (VECS[k]) begin
      wr(VECS[k].idx, VECS[k].sp, VECS[k].ld, VECS[k].d);
      rd(VECS[k].idx, 1'b0);
      chk(VECS[k].sp ? "R1 boxed store" : "R2 raw store", rd_a_data, VECS[k].xd);
      rd(VECS[k].idx, 1'b1);
      chk(VECS[k].xs == NANB ? "R4 bad box" : "R3 good box", rd_a_data, VECS[k].xs);
    end
    chk("R6 still dirty", {62'd0, fs_state}, 64'd3);

    // R9 read during write returns old
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd4; wr_single = 0; wr_data = 64'hAAAA_BBBB_CCCC_DDDD;
    rd(5'd4, 1'b0);
    chk("R9 old value", rd_a_data, 64'hFFFF_FFFF_1234_5678);
    @(negedge clk);
    wr_en = 0;
    rd(5'd4, 1'b0);
    chk("R9 new value", rd_a_data, 64'hAAAA_BBBB_CCCC_DDDD);

    // R5 clean, then R6 write moves to dirty
    setfs(2'd2);
    chk("R5 clean", {62'd0, fs_state}, 64'd2);
    chk("R5 summary clean", {63'd0, fs_summary}, 64'd0);
    wr(5'd11, 1'b1, 1'b1, 64'h5);
    chk("R6 clean to dirty", {62'd0, fs_state}, 64'd3);

    // R11 state load beats dirtying
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd12; wr_single = 0; wr_data = 64'h77;
    fs_set_en = 1; fs_set_val = 2'd2;
    @(negedge clk);
    wr_en = 0; fs_set_en = 0;
    chk("R11 set wins", {62'd0, fs_state}, 64'd2);
    rd(5'd12, 1'b0);
    chk("R11 write still lands", rd_a_data, 64'h77);

    // R7 off
    setfs(2'd0);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd3; wr_single = 0; wr_data = 64'h0BAD;
    #0.5;
    chk("R7 illegal write", {63'd0, illegal}, 64'd1);
    @(negedge clk);
    wr_en = 0;
    rd(5'd3, 1'b0);
    chk("R7 no write", rd_a_data, 64'h4009_21FB_5444_2D18);
    chk("R7 stays off", {62'd0, fs_state}, 64'd0);
    chk_en = 1; chk_single = 1; #0.5;
    chk("R7 store illegal", {63'd0, illegal}, 64'd1);
    chk_en = 0; #0.5;
    chk("R7 idle legal", {63'd0, illegal}, 64'd0);

    // R8 precision gating
    setfs(2'd1);
    f_enable = 0;
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd1; wr_single = 1; wr_data = 64'h4040_0000;
    #0.5;
    chk("R8 single off illegal", {63'd0, illegal}, 64'd1);
    @(negedge clk);
    wr_en = 0;
    rd(5'd1, 1'b0);
    chk("R8 single blocked", rd_a_data, 64'hFFFF_FFFF_3F80_0000);
    chk("R8 no dirty", {62'd0, fs_state}, 64'd1);
    chk_en = 1; chk_single = 0; #0.5;
    chk("R8 double ok with F off", {63'd0, illegal}, 64'd0);
    chk_en = 0;
    f_enable = 1; d_enable = 0;
    @(negedge clk);
    wr_en = 1; wr_idx = 5'd1; wr_single = 0; wr_data = 64'h1;
    #0.5;
    chk("R8 double off illegal", {63'd0, illegal}, 64'd1);
    @(negedge clk);
    wr_en = 0;
    rd(5'd1, 1'b0);
    chk("R8 double blocked", rd_a_data, 64'hFFFF_FFFF_3F80_0000);
    wr(5'd1, 1'b1, 1'b0, 64'h4040_0000);
    rd(5'd1, 1'b0);
    chk("R8 single ok with D off", rd_a_data, 64'hFFFF_FFFF_4040_0000);
    d_enable = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule